// File: doc/BRIEF.md
# Parallel Video Embedded-Sync Receiver

This block takes a 20-bit parallel video bus that is sampled on every pixel clock. It extracts active-video samples using the timing reference sequences embedded in the stream. In single-stream mode each clock carries one sample. In dual-stream mode each clock carries two 10-bit samples: luma in the upper half and chroma in the lower half. A width setting N keeps the upper N bits of each sample and zeroes the rest. Each sync sequence is a three-word preamble followed by a status word. The preamble is not fixed. It comes from a configuration word and is compared against the truncated samples, so a sensor that drives 8-bit codes onto a 10-bit lane can still be matched.

The status word that follows a matched preamble carries three flags: the field, vertical blanking, and whether the code marks the end or the start of active video. Samples between a start code outside blanking and the next end code leave the block with a valid strobe. They are tagged with line-start, frame-start and field. The block holds a short delay line so that it can withdraw preamble words that were already accepted as video by the time the status word identifies them.

Top module: `pvrx_sync_rx`

## Requirements
- R1: Single-stream mode: the output sample is the bus with its lowest 20-N bits forced to zero. N is `width_sel` clamped to the range 8 to 16.
- R2: Dual-stream mode: each 10-bit half (luma in bits 19:10, chroma in bits 9:0) keeps its top min(N,10) bits. Both halves come out together under one valid strobe.
- R3: Single-stream mode: preamble word 0 is `preamble[23:16]`, word 1 is `[15:8]` and word 2 is `[7:0]`. Each word is compared with bits 19:12 of the truncated bus. Bits 29:24 have no effect.
- R4: Dual-stream mode: preamble word 0 is `preamble[29:20]`, word 1 is `[19:10]` and word 2 is `[9:0]`. Each word is compared with the truncated luma half. Chroma is never searched.
- R5: The preamble words must match in order on consecutive samples. On a mismatch the search restarts, and the failing sample is tested again as word 0.
- R6: The sample after a full preamble is the status word: F = bit 18, V = bit 17, H = bit 16 (H=1 end code, H=0 start code). Only a start code with V=0 opens active video. The next end code closes it.
- R7: Preamble and status words never appear as valid output. A video sample sampled at clock edge k appears on the outputs after edge k+3.
- R8: `line_start` is high together with the first valid sample after each start code, and only then.
- R9: `frame_start` marks the first sample of the first active line after one of two events: a status word with F falling from 1 to 0, or, while F has not yet been 1 since enable, any status word with V=1 and F=0.
- R10: `field` carries the F bit of the most recent status word, aligned with the sample it accompanies.
- R11: `dual_mode`, `width_sel` and `preamble` are captured only during reset or while `en` is low. Changes while enabled have no effect.
- R12: While `en` is low, and in reset, `pix_vld`, `line_start` and `frame_start` are low. Raising `en` restarts the search and discards any partly matched preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Receiver enable; low clears and reloads settings |
| dual_mode | input | 1 | 1: two samples per clock, 0: one sample per clock |
| width_sel | input | 5 | Sample width N (clamped 8..16) |
| preamble | input | 30 | Three packed preamble words |
| vid_bus | input | 20 | Incoming video bus |
| pix | output | 20 | Truncated active-video sample(s) |
| pix_vld | output | 1 | Sample valid |
| line_start | output | 1 | First sample of a line |
| frame_start | output | 1 | First sample of a frame |
| field | output | 1 | Field bit carried with the sample |

## Verification
The assertions check four things on every cycle: active video opens only through a decoded status word, a status word always withdraws the three queued preamble words, the strobes stay consistent (frame-start implies line-start, which implies valid), and the captured settings hold steady while enabled. The bench scenarios are needed for everything that depends on data content: the truncation values for each mode and width, preamble matching after truncation, restarts of the search, the frame-start rules for interlaced and progressive sequences, the fixed output latency, and the loss of a partial preamble across an enable toggle.

// File: rtl/pvrx_pkg.sv
// Shared constants, the delay-line entry type and the truncation mask.
// Assumes a 20-bit bus split into two 10-bit halves in dual-stream mode.
package pvrx_pkg;
    localparam int BUS_W    = 20;
    localparam int HALF_W   = BUS_W / 2;
    localparam int NARROW_W = 8;
    localparam int NWORDS   = 3;
    localparam int PRE_W    = NWORDS * HALF_W;
    localparam int WID_W    = 5;
    localparam int MIN_WID  = 8;
    localparam int MAX_WID  = 16;
    localparam int BIT_F    = BUS_W - 2;
    localparam int BIT_V    = BUS_W - 3;
    localparam int BIT_H    = BUS_W - 4;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             vld;
        logic             sol;
        logic             sof;
        logic             fld;
    } tap_t;

    // Mask keeping the top N bits (single) or top min(N,HALF_W) bits per half (dual).
    function automatic logic [BUS_W-1:0] keep_mask(input logic dual, input logic [WID_W-1:0] wid);
        int n;
        int nh;
        logic [BUS_W-1:0] m;
        n = int'(wid);
        if (n < MIN_WID) n = MIN_WID;
        if (n > MAX_WID) n = MAX_WID;
        nh = (n > HALF_W) ? HALF_W : n;
        m = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (dual) m[i] = ((i % HALF_W) >= (HALF_W - nh));
            else      m[i] = (i >= (BUS_W - n));
        end
        return m;
    endfunction
endpackage

// File: rtl/pvrx_trunc.sv
// Drops the unused low bits of each incoming sample according to mode and width.
// Assumes the settings are already held stable by the caller.
module pvrx_trunc
    import pvrx_pkg::*;
(
    input  logic             dual_i,
    input  logic [WID_W-1:0] wid_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] smp_o
);
    // Apply the computed keep-mask to the raw bus.
    assign smp_o = bus_i & keep_mask(dual_i, wid_i);
endmodule

// File: rtl/pvrx_detect.sv
// Preamble matcher and status-word decoder. It tracks the active-video window and the
// pending line and frame markers. Assumes key_i is the truncated compare field, with
// narrow codes left-aligned, and flags_i is {F,V,H} of the same sample.
module pvrx_detect
    import pvrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              dual_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [HALF_W-1:0] key_i,
    input  logic [2:0]        flags_i,
    output logic              xy_o,
    output logic              active_o,
    output logic              sol_pend_o,
    output logic              sof_pend_o,
    output logic              fld_o
);
    localparam int CNT_W = $clog2(NWORDS + 1);

    logic [CNT_W-1:0]  mcnt;
    logic [NWORDS-1:0] hit;
    logic              hit_cur;
    logic              last_f, seen_f1;
    logic              f_b, v_b, h_b;

    assign {f_b, v_b, h_b} = flags_i;

    // One comparator per preamble word; narrow words are zero-padded on the right.
    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [HALF_W-1:0] wd;
        assign wd = dual_i ? pre_i[PRE_W-1-k*HALF_W -: HALF_W]
                           : {pre_i[NWORDS*NARROW_W-1-k*NARROW_W -: NARROW_W],
                              {(HALF_W-NARROW_W){1'b0}}};
        assign hit[k] = (key_i == wd);
    end

    // Select the comparator for the word currently expected.
    always_comb begin
        hit_cur = 1'b0;
        for (int k = 0; k < NWORDS; k++)
            if (int'(mcnt) == k) hit_cur = hit[k];
    end

    assign xy_o = en_i && (mcnt == CNT_W'(NWORDS));

    // Advance the matcher and decode status words into window and marker state.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            mcnt       <= '0;
            active_o   <= 1'b0;
            sol_pend_o <= 1'b0;
            sof_pend_o <= 1'b0;
            last_f     <= 1'b0;
            seen_f1    <= 1'b0;
            fld_o      <= 1'b0;
        end else if (xy_o) begin
            mcnt       <= '0;
            last_f     <= f_b;
            fld_o      <= f_b;
            if (f_b) seen_f1 <= 1'b1;
            active_o   <= !h_b && !v_b;
            sol_pend_o <= !h_b && !v_b;
            if ((last_f && !f_b) || (v_b && !f_b && !seen_f1)) sof_pend_o <= 1'b1;
        end else begin
            if (hit_cur)     mcnt <= mcnt + CNT_W'(1);
            else if (hit[0]) mcnt <= CNT_W'(1);
            else             mcnt <= '0;
            if (active_o && sol_pend_o) begin
                sol_pend_o <= 1'b0;
                sof_pend_o <= 1'b0;
            end
        end
    end

    // R6
    sav_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(xy_o));
endmodule

// File: rtl/pvrx_align.sv
// Delay line of NWORDS+1 entries. When a status word is seen, it withdraws the
// NWORDS entries just queued, which are the preamble. Assumes kill_i pulses only on
// the sample that follows a complete preamble.
module pvrx_align
    import pvrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic kill_i,
    input  tap_t tap_i,
    output tap_t tap_o
);
    localparam int DEPTH = NWORDS + 1;

    tap_t pipe [DEPTH];

    // Shift entries; a status word clears the flags of the entries it retracts.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= tap_i;
            for (int i = 1; i < DEPTH; i++) begin
                if (kill_i)
                    pipe[i] <= '{data: pipe[i-1].data, vld: 1'b0, sol: 1'b0,
                                 sof: 1'b0, fld: pipe[i-1].fld};
                else
                    pipe[i] <= pipe[i-1];
            end
        end
    end

    assign tap_o = pipe[DEPTH-1];

    // R7
    sync_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !tap_o.vld);
    // R12
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tap_o.vld);
endmodule

// File: rtl/pvrx_sync_rx.sv
// Top of the parallel video embedded-sync receiver. It latches the settings while
// disabled, truncates the bus, runs the sync detector on the (luma) compare field and
// emits aligned active-video samples with line, frame and field markers.
module pvrx_sync_rx
    import pvrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dual_mode,
    input  logic [WID_W-1:0]  width_sel,
    input  logic [PRE_W-1:0]  preamble,
    input  logic [BUS_W-1:0]  vid_bus,
    output logic [BUS_W-1:0]  pix,
    output logic              pix_vld,
    output logic              line_start,
    output logic              frame_start,
    output logic              field
);
    logic              cfg_dual;
    logic [WID_W-1:0]  cfg_wid;
    logic [PRE_W-1:0]  cfg_pre;
    logic [BUS_W-1:0]  smp;
    logic [HALF_W-1:0] key;
    logic              xy, active, sol_pend, sof_pend, fld, vld_in;
    tap_t              tap_in, tap_out;

    // Capture the settings only in reset or while the receiver is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cfg_dual <= dual_mode;
            cfg_wid  <= width_sel;
            cfg_pre  <= preamble;
        end
    end

    pvrx_trunc u_trunc (
        .dual_i (cfg_dual),
        .wid_i  (cfg_wid),
        .bus_i  (vid_bus),
        .smp_o  (smp)
    );

    // Compare field: whole luma half, or the narrow top field padded on the right.
    assign key = cfg_dual ? smp[BUS_W-1 -: HALF_W]
                          : {smp[BUS_W-1 -: NARROW_W], {(HALF_W-NARROW_W){1'b0}}};

    pvrx_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .dual_i     (cfg_dual),
        .pre_i      (cfg_pre),
        .key_i      (key),
        .flags_i    ({smp[BIT_F], smp[BIT_V], smp[BIT_H]}),
        .xy_o       (xy),
        .active_o   (active),
        .sol_pend_o (sol_pend),
        .sof_pend_o (sof_pend),
        .fld_o      (fld)
    );

    // Tag the incoming sample; the status word itself is never video.
    assign vld_in = active && !xy;
    assign tap_in = '{data: smp, vld: vld_in, sol: vld_in && sol_pend,
                      sof: vld_in && sol_pend && sof_pend, fld: fld};

    pvrx_align u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .kill_i (xy),
        .tap_i  (tap_in),
        .tap_o  (tap_out)
    );

    assign pix         = tap_out.data;
    assign pix_vld     = tap_out.vld;
    assign line_start  = tap_out.sol;
    assign frame_start = tap_out.sof;
    assign field       = tap_out.fld;

    // R8
    sol_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> pix_vld);
    // R9
    sof_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);
    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(rst_n)) |-> ($stable(cfg_wid) && $stable(cfg_pre) && $stable(cfg_dual)));
endmodule

// File: tb/sim_pvrx_sync_rx.sv
// Self-checking bench: a vector table of truncation and matching cases, then directed tests.
module sim_pvrx_sync_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        dual_mode = 1'b0;
    logic [4:0]  width_sel = 5'd16;
    logic [29:0] preamble = 30'h00FF0000;
    logic [19:0] vid_bus = '0;
    logic [19:0] pix;
    logic        pix_vld, line_start, frame_start, field;

    always #10 clk = ~clk;

    pvrx_sync_rx u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .dual_mode(dual_mode),
        .width_sel(width_sel), .preamble(preamble), .vid_bus(vid_bus),
        .pix(pix), .pix_vld(pix_vld), .line_start(line_start),
        .frame_start(frame_start), .field(field)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    logic [19:0] cap_pix [256];
    logic        cap_sol [256];
    logic        cap_sof [256];
    logic        cap_fld [256];
    int          cap_cyc [256];

    always @(posedge clk) cyc <= cyc + 1;

    // Record every valid output sample, sampled between edges.
    always @(negedge clk) begin
        if (pix_vld && cap_n < 256) begin
            cap_pix[cap_n] = pix;
            cap_sol[cap_n] = line_start;
            cap_sof[cap_n] = frame_start;
            cap_fld[cap_n] = field;
            cap_cyc[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 60000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired act=%0d exp<=60000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drv(input logic [19:0] v);
        @(negedge clk);
        vid_bus = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(20'h0);
    endtask

    task automatic trs(input logic [19:0] w0, input bit f, input bit v, input bit h);
        drv(w0);
        drv(20'h0);
        drv(20'h0);
        drv({1'b1, f, v, h, 16'h0});
    endtask

    task automatic cfg(input bit d, input logic [4:0] w, input logic [29:0] p);
        @(negedge clk);
        en = 1'b0;
        dual_mode = d;
        width_sel = w;
        preamble = p;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // {dual, width, preamble, first preamble bus word, data, expected pix}
    localparam logic [95:0] VEC [9] = '{
        {1'b0, 5'd16, 30'h00FF0000, 20'hFF000, 20'h12345, 20'h12340},
        {1'b0, 5'd8,  30'h00FF0000, 20'hFF000, 20'hABCDE, 20'hAB000},
        {1'b0, 5'd12, 30'h00FF0000, 20'hFF000, 20'h5A5A5, 20'h5A500},
        {1'b0, 5'd20, 30'h00FF0000, 20'hFF000, 20'h13579, 20'h13570},
        {1'b0, 5'd4,  30'h00FF0000, 20'hFF000, 20'h13579, 20'h13000},
        {1'b0, 5'd8,  30'h3FFF0000, 20'hFF000, 20'h55555, 20'h55000},
        {1'b1, 5'd10, 30'h3FF00000, 20'hFFC00, 20'h12345, 20'h12345},
        {1'b1, 5'd16, 30'h3FF00000, 20'hFFC00, 20'h2ABCD, 20'h2ABCD},
        {1'b1, 5'd8,  30'h3FC00000, 20'hFFC00, 20'h2ABCD, 20'h2A3CC}
    };

    initial begin
        int base;
        int c0;
        // Reset state (R12)
        repeat (3) @(negedge clk);
        chk("R12 reset pix_vld", {31'b0, pix_vld}, 32'd0);
        chk("R12 reset line_start", {31'b0, line_start}, 32'd0);
        chk("R12 reset frame_start", {31'b0, frame_start}, 32'd0);
        rst_n = 1'b1;

        // Vector table: truncation (R1, R2) and preamble matching (R3, R4)
        for (int e = 0; e < 9; e++) begin
            cfg(VEC[e][95], VEC[e][94:90], VEC[e][89:60]);
            idle(2);
            base = cap_n;
            trs(VEC[e][59:40], 1'b0, 1'b0, 1'b0);
            drv(VEC[e][39:20]);
            trs(VEC[e][59:40], 1'b0, 1'b0, 1'b1);
            idle(6);
            chk(VEC[e][95] ? "R4 detect count" : "R3 detect count", cap_n - base, 32'd1);
            chk(VEC[e][95] ? "R2 dual pix" : "R1 single pix", {12'b0, cap_pix[base]}, {12'b0, VEC[e][19:0]});
            chk("R8 sol on lone sample", {31'b0, cap_sol[base]}, 32'd1);
        end

        // R5: restart on mismatch, and partial preambles inside video stay video
        cfg(1'b0, 5'd8, 30'h00FF0000);
        idle(2);
        base = cap_n;
        drv(20'hFF000);
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'h11000);
        drv(20'hFF000);
        drv(20'h00000);
        drv(20'h12000);
        trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        idle(6);
        chk("R5 count", cap_n - base, 32'd4);
        chk("R5 first", {12'b0, cap_pix[base]}, 32'h11000);
        chk("R5 partial kept", {12'b0, cap_pix[base+1]}, 32'hFF000);
        chk("R5 last", {12'b0, cap_pix[base+3]}, 32'h12000);

        // R6: start code inside vertical blanking opens no video
        base = cap_n;
        trs(20'hFF000, 1'b0, 1'b1, 1'b0);
        drv(20'h22000);
        drv(20'h33000);
        trs(20'hFF000, 1'b0, 1'b1, 1'b1);
        idle(6);
        chk("R6 blank line silent", cap_n - base, 32'd0);

        // R7 latency, R8 line start per line
        cfg(1'b0, 5'd8, 30'h00FF0000);
        idle(2);
        base = cap_n;
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'hA1000);
        c0 = cyc;
        drv(20'hA2000);
        drv(20'hA3000);
        trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'hB1000);
        drv(20'hB2000);
        trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        idle(6);
        chk("R7 count no sync words", cap_n - base, 32'd5);
        chk("R7 latency", cap_cyc[base] - c0, 32'd4);
        chk("R8 first sol", {31'b0, cap_sol[base]}, 32'd1);
        chk("R8 second no sol", {31'b0, cap_sol[base+1]}, 32'd0);
        chk("R8 next line sol", {31'b0, cap_sol[base+3]}, 32'd1);
        chk("R7 next line data", {12'b0, cap_pix[base+3]}, 32'hB1000);

        // R9 progressive: blanking with F=0 then two active lines
        cfg(1'b0, 5'd8, 30'h00FF0000);
        idle(2);
        base = cap_n;
        trs(20'hFF000, 1'b0, 1'b1, 1'b1);
        trs(20'hFF000, 1'b0, 1'b1, 1'b0);
        for (int l = 0; l < 2; l++) begin
            trs(20'hFF000, 1'b0, 1'b0, 1'b0);
            drv(20'h44000);
            drv(20'h45000);
            trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        end
        idle(6);
        chk("R9 prog count", cap_n - base, 32'd4);
        chk("R9 prog sof first", {31'b0, cap_sof[base]}, 32'd1);
        chk("R9 prog sof second sample", {31'b0, cap_sof[base+1]}, 32'd0);
        chk("R9 prog sof second line", {31'b0, cap_sof[base+2]}, 32'd0);

        // R9/R10 interlaced: field 1 line, then F falls to 0
        cfg(1'b0, 5'd8, 30'h00FF0000);
        idle(2);
        base = cap_n;
        trs(20'hFF000, 1'b1, 1'b1, 1'b1);
        trs(20'hFF000, 1'b1, 1'b0, 1'b0);
        drv(20'h46000);
        trs(20'hFF000, 1'b1, 1'b0, 1'b1);
        trs(20'hFF000, 1'b0, 1'b1, 1'b1);
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'h47000);
        trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        idle(6);
        chk("R9 intl count", cap_n - base, 32'd2);
        chk("R10 field one", {31'b0, cap_fld[base]}, 32'd1);
        chk("R9 no sof in field one", {31'b0, cap_sof[base]}, 32'd0);
        chk("R10 field zero", {31'b0, cap_fld[base+1]}, 32'd0);
        chk("R9 sof after F fall", {31'b0, cap_sof[base+1]}, 32'd1);

        // R11: settings changed while enabled are ignored
        cfg(1'b0, 5'd16, 30'h00FF0000);
        width_sel = 5'd8;
        preamble = 30'h0;
        dual_mode = 1'b1;
        idle(2);
        base = cap_n;
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'h12345);
        trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        idle(6);
        chk("R11 still detects", cap_n - base, 32'd1);
        chk("R11 old width kept", {12'b0, cap_pix[base]}, 32'h12340);

        // R12: disabling mid-line drops video; enable rise forgets partial preamble
        cfg(1'b0, 5'd8, 30'h00FF0000);
        idle(2);
        base = cap_n;
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'h61000);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 quiet while off", {31'b0, pix_vld}, 32'd0);
        en = 1'b1;
        drv(20'hFF000);
        drv(20'h00000);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        drv(20'h00000);
        drv({1'b1, 1'b0, 1'b0, 1'b0, 16'h0});
        drv(20'h62000);
        drv(20'h63000);
        idle(6);
        chk("R12 no video after toggle", cap_n - base, 32'd0);
        base = cap_n;
        trs(20'hFF000, 1'b0, 1'b0, 1'b0);
        drv(20'h64000);
        trs(20'hFF000, 1'b0, 1'b0, 1'b1);
        idle(6);
        chk("R12 search works again", cap_n - base, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule